// File: doc/BRIEF.md
# Sleep-Mode Power Controller

This controller sits between a processor, the clock system and the wake sources. The processor picks one of five sleep modes and issues a sleep command. The controller then switches off the clock enables that the chosen mode does not need. These are the CPU, non-volatile memory, peripheral, real-time-counter and main-oscillator enables. While the device sleeps, the controller watches the wake requests. Only the sources that the latched mode allows can bring the device back to active operation.

Some modes switch off the main oscillator. Waking from one of them passes through a stabilization phase: the oscillator enable comes back first, and the CPU clock stays off until a set number of oscillator-ready cycles have been counted. Modes that keep the oscillator running return to active operation on the cycle after the wake request. A status output gives the controller state.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After synchronous reset the state is ACTIVE and all five clock enables are high. The state encoding on `state_o` is ACTIVE=00, SLEEPING=01, WAKING=10, and no other code ever appears.
- R2: A sleep command has no effect unless `sleep_en` is high in the same cycle.
- R3: The mode codes on `mode_sel` are 000 light idle, 010 deep off, 011 timed save, 110 deep standby and 111 timed standby. The mode is latched when sleep is entered.
- R4: The codes 001, 100 and 101 behave exactly like light idle.
- R5: While SLEEPING, the CPU and memory enables are low. The peripheral enable is high only in light idle. The RTC enable is high in light idle, timed save and timed standby. The oscillator enable is high in light idle, deep standby and timed standby.
- R6: `wake_async` or `wake_twi` ends sleep in every mode.
- R7: `irq_any` ends sleep only in light idle. In every other mode it is ignored.
- R8: `irq_rtc` ends sleep in light idle, timed save and timed standby. In deep off and deep standby it is ignored.
- R9: A wake from deep off or timed save moves to WAKING. In WAKING the oscillator enable is high and the CPU enable is low. The state becomes ACTIVE on the cycle after the STAB_CYCLES-th cycle with `osc_rdy` high.
- R10: Cycles in WAKING with `osc_rdy` low do not advance the stabilization count.
- R11: A wake from a mode that keeps the oscillator running goes straight to ACTIVE on the next cycle.
- R12: If any wake request is present in the same cycle as an accepted sleep command, the controller stays ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_en | input | 1 | Sleep permission bit |
| sleep_cmd | input | 1 | Sleep command pulse from the CPU |
| mode_sel | input | 3 | Requested sleep mode code |
| irq_any | input | 1 | Any enabled interrupt request |
| irq_rtc | input | 1 | Real-time-counter interrupt request |
| wake_async | input | 1 | Asynchronous pin wake request |
| wake_twi | input | 1 | Two-wire address match wake request |
| osc_rdy | input | 1 | Oscillator ready tick |
| cpu_clk_en | output | 1 | CPU clock enable |
| nvm_clk_en | output | 1 | Non-volatile memory clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| rtc_clk_en | output | 1 | RTC clock enable |
| osc_en | output | 1 | Main oscillator enable |
| state_o | output | 2 | Controller state |

## Verification
The hardest case to reach is the middle of the WAKING phase. It can only be entered through a wake that the latched mode accepts, and only when that mode stopped the oscillator. Once there, the controller must hold on through ready ticks that arrive with gaps between them. The stimulus table walks every mode code, including the reserved ones, and offers each wake source in turn. Where a mode ends in WAKING, `osc_rdy` is pulsed with a low cycle between pulses, and the state is checked after each pulse until the final count.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    localparam logic [2:0] MODE_IDLE  = 3'b000;
    localparam logic [2:0] MODE_OFF   = 3'b010;
    localparam logic [2:0] MODE_SAVE  = 3'b011;
    localparam logic [2:0] MODE_STBY  = 3'b110;
    localparam logic [2:0] MODE_XSTBY = 3'b111;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'b00,
        ST_SLEEP  = 2'b01,
        ST_WAKE   = 2'b10
    } pwr_state_e;

    typedef struct packed {
        logic per_on;
        logic rtc_on;
        logic osc_on;
        logic irq_wakes;
        logic rtc_wakes;
    } mode_cfg_t;

    typedef struct packed {
        logic cpu;
        logic nvm;
        logic per;
        logic rtc;
        logic osc;
    } clk_en_t;

    localparam mode_cfg_t CFG_IDLE = '{per_on: 1'b1, rtc_on: 1'b1, osc_on: 1'b1,
                                       irq_wakes: 1'b1, rtc_wakes: 1'b1};

    function automatic mode_cfg_t decode_mode(input logic [2:0] code);
        mode_cfg_t c;
        case (code)
            MODE_OFF:   c = '{per_on: 1'b0, rtc_on: 1'b0, osc_on: 1'b0,
                              irq_wakes: 1'b0, rtc_wakes: 1'b0};
            MODE_SAVE:  c = '{per_on: 1'b0, rtc_on: 1'b1, osc_on: 1'b0,
                              irq_wakes: 1'b0, rtc_wakes: 1'b1};
            MODE_STBY:  c = '{per_on: 1'b0, rtc_on: 1'b0, osc_on: 1'b1,
                              irq_wakes: 1'b0, rtc_wakes: 1'b0};
            MODE_XSTBY: c = '{per_on: 1'b0, rtc_on: 1'b1, osc_on: 1'b1,
                              irq_wakes: 1'b0, rtc_wakes: 1'b1};
            default:    c = CFG_IDLE;  // R4: reserved codes fold onto light idle
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sleep_mode_dec.sv
module sleep_mode_dec
    import pwr_sleep_pkg::*;
(
    input  logic [2:0] code,
    output mode_cfg_t  cfg
);
    always_comb begin
        cfg = decode_mode(code);
    end
endmodule

// File: rtl/sleep_wake_filt.sv
module sleep_wake_filt
    import pwr_sleep_pkg::*;
(
    input  mode_cfg_t cfg,
    input  logic      irq_any,
    input  logic      irq_rtc,
    input  logic      wake_async,
    input  logic      wake_twi,
    output logic      hit
);
    logic always_src;
    logic gated_src;

    always_comb begin
        always_src = wake_async | wake_twi;
        gated_src  = (cfg.irq_wakes & irq_any) | (cfg.rtc_wakes & irq_rtc);
        hit        = always_src | gated_src;
    end
endmodule

// File: rtl/sleep_stab_cnt.sv
module sleep_stab_cnt #(
    parameter int STAB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (STAB_CYCLES < 2) ? 1 : $clog2(STAB_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        done = run && tick && (cnt_q == LAST);
    end
endmodule

// File: rtl/sleep_clk_gate.sv
module sleep_clk_gate
    import pwr_sleep_pkg::*;
(
    input  pwr_state_e state,
    input  mode_cfg_t  cfg,
    output clk_en_t    en
);
    always_comb begin
        case (state)
            ST_SLEEP: en = '{cpu: 1'b0, nvm: 1'b0, per: cfg.per_on,
                             rtc: cfg.rtc_on, osc: cfg.osc_on};
            ST_WAKE:  en = '{cpu: 1'b0, nvm: 1'b0, per: cfg.per_on,
                             rtc: cfg.rtc_on, osc: 1'b1};
            default:  en = '{cpu: 1'b1, nvm: 1'b1, per: 1'b1,
                             rtc: 1'b1, osc: 1'b1};
        endcase
    end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int STAB_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_en,
    input  logic       sleep_cmd,
    input  logic [2:0] mode_sel,
    input  logic       irq_any,
    input  logic       irq_rtc,
    input  logic       wake_async,
    input  logic       wake_twi,
    input  logic       osc_rdy,
    output logic       cpu_clk_en,
    output logic       nvm_clk_en,
    output logic       per_clk_en,
    output logic       rtc_clk_en,
    output logic       osc_en,
    output logic [1:0] state_o
);
    pwr_state_e state_q, state_d;
    mode_cfg_t  cfg_q, cfg_new;
    clk_en_t    en;
    logic       wake_hit;
    logic       any_wake;
    logic       stab_done;
    logic       enter;

    sleep_mode_dec u_dec (
        .code (mode_sel),
        .cfg  (cfg_new)
    );

    sleep_wake_filt u_filt (
        .cfg        (cfg_q),
        .irq_any    (irq_any),
        .irq_rtc    (irq_rtc),
        .wake_async (wake_async),
        .wake_twi   (wake_twi),
        .hit        (wake_hit)
    );

    sleep_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == ST_WAKE),
        .tick (osc_rdy),
        .done (stab_done)
    );

    sleep_clk_gate u_gate (
        .state (state_q),
        .cfg   (cfg_q),
        .en    (en)
    );

    always_comb begin
        any_wake = irq_any | irq_rtc | wake_async | wake_twi;
        enter    = sleep_cmd & sleep_en & ~any_wake;
        state_d  = state_q;
        case (state_q)
            ST_ACTIVE: if (enter) state_d = ST_SLEEP;
            ST_SLEEP:  if (wake_hit) state_d = cfg_q.osc_on ? ST_ACTIVE : ST_WAKE;
            ST_WAKE:   if (stab_done) state_d = ST_ACTIVE;
            default:   state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACTIVE;
            cfg_q   <= CFG_IDLE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ACTIVE && enter) begin
                cfg_q <= cfg_new;
            end
        end
    end

    always_comb begin
        cpu_clk_en = en.cpu;
        nvm_clk_en = en.nvm;
        per_clk_en = en.per;
        rtc_clk_en = en.rtc;
        osc_en     = en.osc;
        state_o    = state_q;
    end
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       sleep_en,
    input logic       sleep_cmd,
    input logic       irq_any,
    input logic       irq_rtc,
    input logic       wake_async,
    input logic       wake_twi,
    input logic       cpu_clk_en,
    input logic       osc_en,
    input logic [1:0] state_o
);
    assert_legal_state_R1: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'b11);

    assert_cpu_off_asleep_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'b00) |-> !cpu_clk_en);

    assert_async_wake_R6: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && (wake_async || wake_twi)) |=> state_o != 2'b01);

    assert_stab_path_R9: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && !osc_en && (wake_async || wake_twi)) |=> state_o == 2'b10);

    assert_osc_on_waking_R9: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b10) |-> osc_en);

    assert_fast_path_R11: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && osc_en && wake_async) |=> state_o == 2'b00);

    assert_cancel_R12: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00 && sleep_cmd && sleep_en &&
         (irq_any || irq_rtc || wake_async || wake_twi)) |=> state_o == 2'b00);
endmodule

bind pwr_sleep_ctrl sleep_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep_en   (sleep_en),
    .sleep_cmd  (sleep_cmd),
    .irq_any    (irq_any),
    .irq_rtc    (irq_rtc),
    .wake_async (wake_async),
    .wake_twi   (wake_twi),
    .cpu_clk_en (cpu_clk_en),
    .osc_en     (osc_en),
    .state_o    (state_o)
);

// File: tb/pwr_sleep_ctrl_test.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_test;
    localparam int STAB = 4;

    // {mode[2:0], per, rtc, osc, irq_wakes, rtc_wakes, needs_stab}
    localparam logic [8:0] VEC [8] = '{
        {3'b000, 6'b111110},
        {3'b001, 6'b111110},
        {3'b010, 6'b000001},
        {3'b011, 6'b010011},
        {3'b100, 6'b111110},
        {3'b101, 6'b111110},
        {3'b110, 6'b001000},
        {3'b111, 6'b011010}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_en = 1'b0, sleep_cmd = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic irq_any = 1'b0, irq_rtc = 1'b0, wake_async = 1'b0, wake_twi = 1'b0;
    logic osc_rdy = 1'b0;
    logic cpu_clk_en, nvm_clk_en, per_clk_en, rtc_clk_en, osc_en;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_sleep_ctrl #(.STAB_CYCLES(STAB)) uut (
        .clk(clk), .rst(rst), .sleep_en(sleep_en), .sleep_cmd(sleep_cmd),
        .mode_sel(mode_sel), .irq_any(irq_any), .irq_rtc(irq_rtc),
        .wake_async(wake_async), .wake_twi(wake_twi), .osc_rdy(osc_rdy),
        .cpu_clk_en(cpu_clk_en), .nvm_clk_en(nvm_clk_en), .per_clk_en(per_clk_en),
        .rtc_clk_en(rtc_clk_en), .osc_en(osc_en), .state_o(state_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ens();
        return {3'b000, cpu_clk_en, nvm_clk_en, per_clk_en, rtc_clk_en, osc_en};
    endfunction

    task automatic go_sleep(input logic [2:0] m);
        @(negedge clk);
        sleep_en = 1'b1; sleep_cmd = 1'b1; mode_sel = m;
        @(negedge clk);
        sleep_cmd = 1'b0;
    endtask

    // drive {irq_any, irq_rtc, wake_async, wake_twi} for one cycle
    task automatic pulse_src(input logic [3:0] s);
        @(negedge clk);
        {irq_any, irq_rtc, wake_async, wake_twi} = s;
        @(negedge clk);
        {irq_any, irq_rtc, wake_async, wake_twi} = 4'b0000;
    endtask

    task automatic run_stab();
        for (int k = 0; k < STAB - 1; k++) begin
            @(negedge clk); osc_rdy = 1'b1;
            @(negedge clk); osc_rdy = 1'b0;
            check("R9 still waking mid-count", {6'b0, state_o}, 8'h02);
            @(negedge clk);
            check("R10 gap does not advance", {6'b0, state_o}, 8'h02);
        end
        @(negedge clk); osc_rdy = 1'b1;
        @(negedge clk); osc_rdy = 1'b0;
        check("R9 active after final ready", {6'b0, state_o}, 8'h00);
        check("R9 all enables back", ens(), 8'h1f);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] v;
        logic       woke;
        logic [7:0] exp_st;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", {6'b0, state_o}, 8'h00);
        check("R1 reset enables", ens(), 8'h1f);

        // R2: command without permission
        @(negedge clk);
        sleep_en = 1'b0; sleep_cmd = 1'b1; mode_sel = 3'b010;
        @(negedge clk);
        sleep_cmd = 1'b0;
        check("R2 no sleep without enable", {6'b0, state_o}, 8'h00);

        // R3..R11 table walk over all mode codes (R4 reserved rows included)
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            go_sleep(v[8:6]);
            check("R3 sleeping", {6'b0, state_o}, 8'h01);
            check("R5 sleep enables", ens(), {5'b0, 2'b00, v[5], v[4], v[3]});
            woke = 1'b0;
            exp_st = v[0] ? 8'h02 : 8'h00;
            pulse_src(4'b1000);
            check("R7 irq_any response", {6'b0, state_o}, v[2] ? exp_st : 8'h01);
            woke = v[2];
            if (!woke) begin
                pulse_src(4'b0100);
                check("R8 irq_rtc response", {6'b0, state_o}, v[1] ? exp_st : 8'h01);
                woke = v[1];
            end
            if (!woke) begin
                pulse_src((i % 2 == 0) ? 4'b0010 : 4'b0001);
                check("R6 async/twi wake", {6'b0, state_o}, exp_st);
            end
            if (v[0]) begin
                check("R9 waking enables", ens(), {5'b0, 2'b00, v[5], v[4], 1'b1});
                run_stab();
            end else begin
                check("R11 direct return", ens(), 8'h1f);
            end
        end

        // R12: wake present with the command
        @(negedge clk);
        sleep_en = 1'b1; sleep_cmd = 1'b1; mode_sel = 3'b010; irq_any = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0; irq_any = 1'b0;
        check("R12 entry cancelled", {6'b0, state_o}, 8'h00);
        check("R12 enables stay on", ens(), 8'h1f);

        // R3: mode latched at entry, later mode_sel change ignored
        go_sleep(3'b010);
        @(negedge clk); mode_sel = 3'b000;
        pulse_src(4'b1000);
        check("R3 latched mode ignores irq_any", {6'b0, state_o}, 8'h01);
        pulse_src(4'b0010);
        check("R9 latched deep off waking", {6'b0, state_o}, 8'h02);
        run_stab();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule